// File: doc/BRIEF.md
# Node Cache Coherence Controller

This block is the cache-side coherence engine of one node for a single cache line. It holds the line's MESI-style state and its data, and it serves processor reads and writes. A read or write that hits in a suitable state completes locally. Otherwise the block sends a read, read-exclusive or upgrade request to the home node and waits for the answer.

It also acts on messages arriving from the network. Replies end a pending miss. Invalidation acknowledgments are counted until a write may complete. Interventions and invalidations name a third-party requester, and the block sends its data or an acknowledgment straight to that node. When a modified line is demoted, a second port returns a copy of the data to the home node.

Only one miss can be outstanding. While it is in flight, the processor side stays blocked.

Top module: `node_coh_ctrl`

## Requirements
- R1: After reset the line state reads 0 (invalid), no response, network message or write-back is valid, and `cpu_req_ready` is high while no network message is presented.
- R2: A processor read accepted while the line is shared (1), exclusive (2) or modified (3) produces `cpu_resp_valid` with the line data in the next cycle and sends no network message.
- R3: A read accepted on an invalid line sends, in the next cycle, message kind 1 (read) to node `HOME_ID`. An incoming kind 1 (data reply) then ends the miss: the line becomes exclusive if `net_in_excl` is 1, otherwise shared, and the reply data is returned on the response port in the following cycle.
- R4: A write accepted on an exclusive line moves it to modified in the next cycle, stores the data and responds, with no network message.
- R5: A write on a shared line sends kind 3 (upgrade) to home. A write on an invalid line sends kind 2 (read-exclusive) to home. Both start a write miss.
- R6: A write miss completes only when a reply (incoming kind 1 or kind 2, carrying the count in `net_in_acks`) has arrived and as many kind 3 acknowledgments have been seen, whether they came before or after the reply. On completion the line is modified, holds the write data, and the response returns it one cycle later.
- R7: An intervention (incoming kind 4) on an exclusive or modified line sends kind 4 (data) with the line data to `net_in_peer` and leaves the line shared. A modified line also pulses `home_wb_valid` with the data. On a shared or invalid line it changes nothing and sends nothing.
- R8: An invalidation (incoming kind 5) leaves the line invalid. An exclusive or modified line sends kind 4 with its data to `net_in_peer`. A shared or invalid line sends kind 5 (acknowledgment) to `net_in_peer`.
- R9: `cpu_req_ready` is low while a miss is outstanding and in every cycle that `net_in_valid` is high. A request held during such a cycle is not accepted and is taken up later.
- R10: A write accepted on a modified line replaces the data and responds in the next cycle, with no network message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cpu_resp_valid | output | 1 | Request completed |
| cpu_resp_data | output | DATA_W | Read data or written data |
| net_in_valid | input | 1 | Incoming message present |
| net_in_kind | input | 3 | 1 data reply, 2 grant, 3 ack, 4 intervention, 5 invalidation |
| net_in_peer | input | NODE_W | Requester named by a snoop |
| net_in_data | input | DATA_W | Reply data |
| net_in_acks | input | ACK_W | Acknowledgments to expect |
| net_in_excl | input | 1 | Read reply grants exclusive |
| net_out_valid | output | 1 | Outgoing message present |
| net_out_kind | output | 3 | 1 read, 2 read-exclusive, 3 upgrade, 4 data, 5 ack |
| net_out_dest | output | NODE_W | Destination node |
| net_out_data | output | DATA_W | Data for kind 4, else zero |
| home_wb_valid | output | 1 | Copy of modified data to home |
| home_wb_data | output | DATA_W | Write-back data |
| line_state | output | 2 | 0 invalid, 1 shared, 2 exclusive, 3 modified |

## Verification
A processor request and a snoop can arrive in the same cycle. The bench provokes this by holding a write valid while an intervention is presented to a modified line. The reference model expects the snoop to win that cycle: ready is low, the data goes to the named peer together with a home write-back, and the line drops to shared. The held write must then be accepted on the following cycle as an upgrade from the shared state. A second overlap is checked as well: an acknowledgment that arrives before the grant must count toward the total.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    localparam logic [2:0] NI_DATA  = 3'd1;
    localparam logic [2:0] NI_GRANT = 3'd2;
    localparam logic [2:0] NI_IACK  = 3'd3;
    localparam logic [2:0] NI_INTV  = 3'd4;
    localparam logic [2:0] NI_INVL  = 3'd5;

    typedef enum logic [2:0] {
        NO_NONE  = 3'd0,
        NO_READ  = 3'd1,
        NO_READX = 3'd2,
        NO_UPGR  = 3'd3,
        NO_DATA  = 3'd4,
        NO_IACK  = 3'd5
    } out_kind_t;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_RD   = 2'd1,
        MS_WR   = 2'd2
    } miss_t;

    function automatic logic is_owner(line_st_t s);
        return (s == LS_E) || (s == LS_M);
    endfunction

endpackage

// File: rtl/coh_miss_tracker.sv
module coh_miss_tracker
    import coh_pkg::*;
#(
    parameter int ACK_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_rd,
    input  logic             start_wr,
    input  logic             data_rsp,
    input  logic             grant_rsp,
    input  logic             iack,
    input  logic [ACK_W-1:0] ack_need,
    output logic             busy,
    output miss_t            kind,
    output logic             done
);
    // one extra bit so early acknowledgments may drive the count below zero
    localparam int CNT_W = ACK_W + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    miss_t            kind_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             got_q, got_d;

    always_comb begin
        cnt_d = cnt_q;
        got_d = got_q;
        done  = 1'b0;
        case (kind_q)
            MS_RD: done = data_rsp;
            MS_WR: begin
                if (data_rsp || grant_rsp) begin
                    cnt_d = cnt_q + {1'b0, ack_need};
                    got_d = 1'b1;
                end else if (iack) begin
                    cnt_d = cnt_q - ONE;
                end
                done = got_d && (cnt_d == '0);
            end
            default: done = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= MS_IDLE;
            cnt_q  <= '0;
            got_q  <= 1'b0;
        end else if (start_rd) begin
            kind_q <= MS_RD;
        end else if (start_wr) begin
            kind_q <= MS_WR;
            cnt_q  <= '0;
            got_q  <= 1'b0;
        end else if (done) begin
            kind_q <= MS_IDLE;
        end else begin
            cnt_q <= cnt_d;
            got_q <= got_d;
        end
    end

    assign busy = (kind_q != MS_IDLE);
    assign kind = kind_q;

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
(
    input  logic      intv,
    input  logic      invl,
    input  line_st_t  st,
    output logic      send,
    output out_kind_t kind,
    output logic      wb,
    output line_st_t  nxt
);
    always_comb begin
        send = 1'b0;
        kind = NO_NONE;
        wb   = 1'b0;
        nxt  = st;
        if (intv) begin
            if (is_owner(st)) begin
                send = 1'b1;
                kind = NO_DATA;
                wb   = (st == LS_M);
                nxt  = LS_S;
            end
        end else if (invl) begin
            send = 1'b1;
            kind = is_owner(st) ? NO_DATA : NO_IACK;
            nxt  = LS_I;
        end
    end

endmodule

// File: rtl/node_coh_ctrl.sv
module node_coh_ctrl
    import coh_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NODE_W  = 2,
    parameter int ACK_W   = 3,
    parameter int HOME_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_data,
    input  logic              net_in_valid,
    input  logic [2:0]        net_in_kind,
    input  logic [NODE_W-1:0] net_in_peer,
    input  logic [DATA_W-1:0] net_in_data,
    input  logic [ACK_W-1:0]  net_in_acks,
    input  logic              net_in_excl,
    output logic              net_out_valid,
    output logic [2:0]        net_out_kind,
    output logic [NODE_W-1:0] net_out_dest,
    output logic [DATA_W-1:0] net_out_data,
    output logic              home_wb_valid,
    output logic [DATA_W-1:0] home_wb_data,
    output logic [1:0]        line_state
);
    localparam logic [NODE_W-1:0] HOME_NODE = NODE_W'(HOME_ID);

    line_st_t          st_q, st_d;
    logic [DATA_W-1:0] data_q, data_d, wdata_q, wdata_d;
    logic              ov_q, ov_d, wbv_q, wbv_d, rv_q, rv_d;
    out_kind_t         ok_q, ok_d;
    logic [NODE_W-1:0] od_q, od_d;
    logic [DATA_W-1:0] odata_q, odata_d, wbd_q, wbd_d, rdat_q, rdat_d;

    logic      is_intv, is_invl, is_data, is_grant, is_iack;
    logic      busy, miss_done, start_rd, start_wr, cpu_acc;
    miss_t     miss_kind;
    logic      snp_send, snp_wb;
    out_kind_t snp_kind;
    line_st_t  snp_nxt;

    assign is_data  = net_in_valid && (net_in_kind == NI_DATA);
    assign is_grant = net_in_valid && (net_in_kind == NI_GRANT);
    assign is_iack  = net_in_valid && (net_in_kind == NI_IACK);
    assign is_intv  = net_in_valid && (net_in_kind == NI_INTV);
    assign is_invl  = net_in_valid && (net_in_kind == NI_INVL);

    assign cpu_req_ready = !busy && !net_in_valid;
    assign cpu_acc       = cpu_req_valid && cpu_req_ready;

    coh_miss_tracker #(.ACK_W(ACK_W)) u_miss (
        .clk       (clk),
        .rst       (rst),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .data_rsp  (is_data),
        .grant_rsp (is_grant),
        .iack      (is_iack),
        .ack_need  (net_in_acks),
        .busy      (busy),
        .kind      (miss_kind),
        .done      (miss_done)
    );

    coh_snoop_unit u_snoop (
        .intv (is_intv),
        .invl (is_invl),
        .st   (st_q),
        .send (snp_send),
        .kind (snp_kind),
        .wb   (snp_wb),
        .nxt  (snp_nxt)
    );

    always_comb begin
        st_d     = st_q;
        data_d   = data_q;
        wdata_d  = wdata_q;
        ov_d     = 1'b0;
        ok_d     = NO_NONE;
        od_d     = HOME_NODE;
        odata_d  = '0;
        wbv_d    = 1'b0;
        wbd_d    = '0;
        rv_d     = 1'b0;
        rdat_d   = '0;
        start_rd = 1'b0;
        start_wr = 1'b0;
        if (is_intv || is_invl) begin
            st_d    = snp_nxt;
            ov_d    = snp_send;
            ok_d    = snp_kind;
            od_d    = net_in_peer;
            odata_d = (snp_kind == NO_DATA) ? data_q : '0;
            wbv_d   = snp_wb;
            wbd_d   = snp_wb ? data_q : '0;
        end else if (miss_done) begin
            rv_d = 1'b1;
            if (miss_kind == MS_RD) begin
                st_d   = net_in_excl ? LS_E : LS_S;
                data_d = net_in_data;
                rdat_d = net_in_data;
            end else begin
                st_d   = LS_M;
                data_d = wdata_q;
                rdat_d = wdata_q;
            end
        end else if (cpu_acc) begin
            if (!cpu_req_write) begin
                if (st_q != LS_I) begin
                    rv_d   = 1'b1;
                    rdat_d = data_q;
                end else begin
                    ov_d     = 1'b1;
                    ok_d     = NO_READ;
                    start_rd = 1'b1;
                end
            end else begin
                case (st_q)
                    LS_E, LS_M: begin
                        st_d   = LS_M;
                        data_d = cpu_req_wdata;
                        rv_d   = 1'b1;
                        rdat_d = cpu_req_wdata;
                    end
                    LS_S: begin
                        ov_d     = 1'b1;
                        ok_d     = NO_UPGR;
                        start_wr = 1'b1;
                        wdata_d  = cpu_req_wdata;
                    end
                    default: begin
                        ov_d     = 1'b1;
                        ok_d     = NO_READX;
                        start_wr = 1'b1;
                        wdata_d  = cpu_req_wdata;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LS_I;
            data_q  <= '0;
            wdata_q <= '0;
            ov_q    <= 1'b0;
            ok_q    <= NO_NONE;
            od_q    <= '0;
            odata_q <= '0;
            wbv_q   <= 1'b0;
            wbd_q   <= '0;
            rv_q    <= 1'b0;
            rdat_q  <= '0;
        end else begin
            st_q    <= st_d;
            data_q  <= data_d;
            wdata_q <= wdata_d;
            ov_q    <= ov_d;
            ok_q    <= ok_d;
            od_q    <= od_d;
            odata_q <= odata_d;
            wbv_q   <= wbv_d;
            wbd_q   <= wbd_d;
            rv_q    <= rv_d;
            rdat_q  <= rdat_d;
        end
    end

    assign line_state     = st_q;
    assign net_out_valid  = ov_q;
    assign net_out_kind   = ok_q;
    assign net_out_dest   = od_q;
    assign net_out_data   = odata_q;
    assign home_wb_valid  = wbv_q;
    assign home_wb_data   = wbd_q;
    assign cpu_resp_valid = rv_q;
    assign cpu_resp_data  = rdat_q;

endmodule

// File: rtl/coh_ctrl_checker.sv
module coh_ctrl_checker #(
    parameter int NODE_W  = 2,
    parameter int HOME_ID = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_write,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              net_in_valid,
    input logic [2:0]        net_in_kind,
    input logic              net_out_valid,
    input logic [2:0]        net_out_kind,
    input logic [NODE_W-1:0] net_out_dest,
    input logic              home_wb_valid,
    input logic [1:0]        line_state
);
    localparam logic [NODE_W-1:0] HOME_NODE = NODE_W'(HOME_ID);

    logic rd_acc, wr_acc;
    assign rd_acc = cpu_req_valid && cpu_req_ready && !cpu_req_write;
    assign wr_acc = cpu_req_valid && cpu_req_ready && cpu_req_write;

    a_r9_ready_blocked: assert property (@(posedge clk) disable iff (rst)
        net_in_valid |-> !cpu_req_ready);

    a_r2_read_hit: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && line_state != 2'd0) |=> (cpu_resp_valid && !net_out_valid));

    a_r3_read_miss: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && line_state == 2'd0) |=>
        (net_out_valid && net_out_kind == 3'd1 && net_out_dest == HOME_NODE && !cpu_req_ready));

    a_r4_silent_upgrade: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && line_state == 2'd2) |=>
        (!net_out_valid && line_state == 2'd3 && cpu_resp_valid));

    a_r7_modified_intervene: assert property (@(posedge clk) disable iff (rst)
        (net_in_valid && net_in_kind == 3'd4 && line_state == 2'd3) |=>
        (home_wb_valid && net_out_valid && net_out_kind == 3'd4 && line_state == 2'd1));

    a_r7_wb_with_data: assert property (@(posedge clk) disable iff (rst)
        home_wb_valid |-> (net_out_valid && net_out_kind == 3'd4));

    a_r8_invalidate: assert property (@(posedge clk) disable iff (rst)
        (net_in_valid && net_in_kind == 3'd5) |=> (line_state == 2'd0 && net_out_valid));

endmodule

bind node_coh_ctrl coh_ctrl_checker #(
    .NODE_W  (NODE_W),
    .HOME_ID (HOME_ID)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_write  (cpu_req_write),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .net_in_valid   (net_in_valid),
    .net_in_kind    (net_in_kind),
    .net_out_valid  (net_out_valid),
    .net_out_kind   (net_out_kind),
    .net_out_dest   (net_out_dest),
    .home_wb_valid  (home_wb_valid),
    .line_state     (line_state)
);

// File: tb/tb_node_coh_ctrl.sv
module tb_node_coh_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NW = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_req_valid, cpu_req_write;
    logic [DW-1:0] cpu_req_wdata;
    logic          cpu_req_ready, cpu_resp_valid;
    logic [DW-1:0] cpu_resp_data;
    logic          net_in_valid;
    logic [2:0]    net_in_kind;
    logic [NW-1:0] net_in_peer;
    logic [DW-1:0] net_in_data;
    logic [AW-1:0] net_in_acks;
    logic          net_in_excl;
    logic          net_out_valid;
    logic [2:0]    net_out_kind;
    logic [NW-1:0] net_out_dest;
    logic [DW-1:0] net_out_data;
    logic          home_wb_valid;
    logic [DW-1:0] home_wb_data;
    logic [1:0]    line_state;

    node_coh_ctrl #(.DATA_W(DW), .NODE_W(NW), .ACK_W(AW), .HOME_ID(0)) dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_wdata(cpu_req_wdata), .cpu_req_ready(cpu_req_ready),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_data(cpu_resp_data),
        .net_in_valid(net_in_valid), .net_in_kind(net_in_kind),
        .net_in_peer(net_in_peer), .net_in_data(net_in_data),
        .net_in_acks(net_in_acks), .net_in_excl(net_in_excl),
        .net_out_valid(net_out_valid), .net_out_kind(net_out_kind),
        .net_out_dest(net_out_dest), .net_out_data(net_out_data),
        .home_wb_valid(home_wb_valid), .home_wb_data(home_wb_data),
        .line_state(line_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural reference model
    int          m_st   = 0;   // 0 I, 1 S, 2 E, 3 M
    int          m_pend = 0;   // 0 none, 1 read, 2 write
    int          m_need = 0;
    bit          m_got  = 0;
    logic [31:0] m_data = 0, m_wd = 0;
    bit          e_ov = 0, e_wv = 0, e_rv = 0;
    int          e_ok = 0, e_od = 0;
    logic [31:0] e_odata = 0, e_wd = 0, e_rd = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit acc;
        e_ov = 0; e_wv = 0; e_rv = 0;
        acc = cpu_req_valid && (m_pend == 0) && !net_in_valid;
        if (net_in_valid) begin
            case (net_in_kind)
                3'd4: if (m_st >= 2) begin
                    e_ov = 1; e_ok = 4; e_od = net_in_peer; e_odata = m_data;
                    if (m_st == 3) begin e_wv = 1; e_wd = m_data; end
                    m_st = 1;
                end
                3'd5: begin
                    e_ov = 1; e_od = net_in_peer;
                    if (m_st >= 2) begin e_ok = 4; e_odata = m_data; end
                    else e_ok = 5;
                    m_st = 0;
                end
                3'd1, 3'd2, 3'd3: begin
                    if (m_pend == 1 && net_in_kind == 3'd1) begin
                        m_st = net_in_excl ? 2 : 1; m_data = net_in_data;
                        e_rv = 1; e_rd = net_in_data; m_pend = 0;
                    end else if (m_pend == 2) begin
                        if (net_in_kind == 3'd3) m_need = m_need - 1;
                        else begin m_need = m_need + int'(net_in_acks); m_got = 1; end
                        if (m_got && m_need == 0) begin
                            m_st = 3; m_data = m_wd; e_rv = 1; e_rd = m_wd; m_pend = 0;
                        end
                    end
                end
                default: ;
            endcase
        end else if (acc) begin
            if (!cpu_req_write) begin
                if (m_st != 0) begin e_rv = 1; e_rd = m_data; end
                else begin e_ov = 1; e_ok = 1; e_od = 0; m_pend = 1; end
            end else if (m_st >= 2) begin
                m_st = 3; m_data = cpu_req_wdata; e_rv = 1; e_rd = cpu_req_wdata;
            end else begin
                e_ov = 1; e_ok = (m_st == 1) ? 3 : 2; e_od = 0;
                m_pend = 2; m_wd = cpu_req_wdata; m_need = 0; m_got = 0;
            end
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "line_state", 32'(line_state), 32'(m_st));
        chk(tag, "out_valid", 32'(net_out_valid), 32'(e_ov));
        if (e_ov) begin
            chk(tag, "out_kind", 32'(net_out_kind), 32'(e_ok));
            chk(tag, "out_dest", 32'(net_out_dest), 32'(e_od));
            if (e_ok == 4) chk(tag, "out_data", net_out_data, e_odata);
        end
        chk(tag, "wb_valid", 32'(home_wb_valid), 32'(e_wv));
        if (e_wv) chk(tag, "wb_data", home_wb_data, e_wd);
        chk(tag, "resp_valid", 32'(cpu_resp_valid), 32'(e_rv));
        if (e_rv) chk(tag, "resp_data", cpu_resp_data, e_rd);
    endtask

    task automatic cyc(input string tag, input logic cv, input logic cw, input logic [31:0] cd,
                       input logic nv, input logic [2:0] nk, input logic [1:0] np,
                       input logic [31:0] nd, input logic [2:0] na, input logic ne);
        cpu_req_valid = cv; cpu_req_write = cw; cpu_req_wdata = cd;
        net_in_valid = nv; net_in_kind = nk; net_in_peer = np;
        net_in_data = nd; net_in_acks = na; net_in_excl = ne;
        #1;
        chk("R9", "ready", 32'(cpu_req_ready), 32'((m_pend == 0) && !nv));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic cpu(input string tag, input logic w, input logic [31:0] d);
        cyc(tag, 1, w, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic net(input string tag, input logic [2:0] k, input logic [1:0] p,
                       input logic [31:0] d, input logic [2:0] a, input logic e);
        cyc(tag, 0, 0, 0, 1, k, p, d, a, e);
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1;
        cpu_req_valid = 0; cpu_req_write = 0; cpu_req_wdata = 0;
        net_in_valid = 0; net_in_kind = 0; net_in_peer = 0;
        net_in_data = 0; net_in_acks = 0; net_in_excl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        compare("R1");
        #1 chk("R1", "ready", 32'(cpu_req_ready), 32'd1);

        // R3 read miss, held request while pending (R9), exclusive reply
        cpu("R3", 0, 0);
        cyc("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R9", 1, 1, 32'h77, 0, 0, 0, 0, 0, 0);
        net("R3", 3'd1, 0, 32'hA5A5_0001, 0, 1);
        cpu("R2", 0, 0);
        cpu("R4", 1, 32'hB0B0_0002);
        cpu("R10", 1, 32'hC0C0_0003);
        // concurrent snoop and write: snoop wins
        cyc("R9", 1, 1, 32'hD0D0_0004, 1, 3'd4, 2, 0, 0, 0);
        cpu("R5", 1, 32'hD0D0_0004);
        net("R6", 3'd3, 0, 0, 0, 0);
        net("R6", 3'd2, 0, 0, 3'd2, 0);
        idle("R6");
        net("R6", 3'd3, 0, 0, 0, 0);
        net("R7", 3'd4, 1, 0, 0, 0);
        net("R7", 3'd4, 3, 0, 0, 0);
        net("R8", 3'd5, 3, 0, 0, 0);
        net("R8", 3'd5, 1, 0, 0, 0);
        cpu("R5", 1, 32'hE0E0_0005);
        net("R6", 3'd1, 0, 32'hDEAD_BEEF, 0, 0);
        net("R8", 3'd5, 2, 0, 0, 0);
        cpu("R3", 0, 0);
        net("R3", 3'd1, 0, 32'h1111_2222, 0, 0);
        cpu("R2", 0, 0);
        net("R8", 3'd5, 1, 0, 0, 0);
        cpu("R3", 0, 0);
        net("R3", 3'd1, 0, 32'h3333_4444, 0, 1);
        net("R7", 3'd4, 1, 0, 0, 0);
        net("R8", 3'd5, 2, 0, 0, 0);
        cpu("R5", 1, 32'h5555_6666);
        net("R6", 3'd1, 0, 32'h0, 3'd3, 0);
        net("R6", 3'd3, 0, 0, 0, 0);
        net("R6", 3'd3, 0, 0, 0, 0);
        idle("R6");
        net("R6", 3'd3, 0, 0, 0, 0);
        cpu("R2", 0, 0);
        idle("R1");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule